// File: doc/BRIEF.md
# Nibble-Wide Character Display Bridge

This block sits on a simple 32-bit register port and gives a processor access to a character display module through a slow 4-bit parallel link. A processor write or read aimed at the display is accepted at once and carried out later by a small sequencer. The sequencer drives register-select and read/write first, then strobes enable for a minimum pulse width, and then holds the lines. Each processor access moves one nibble, always carried in bus bits [7:4]. Software therefore issues two accesses per display byte, upper nibble first.

A read of the display keeps the returned nibble in a capture register. Completion of every display access raises a sticky done flag. Software clears that flag by writing zero, and it also clears on its own when the next display access is accepted. The done flag ANDed with a mask bit forms both a status bit and the interrupt output. While the sequencer is busy, the bridge refuses further display accesses by dropping `bus_ready`. Accesses to its own registers are still served during that time.

All display timing comes from nanosecond parameters and the clock period parameter. With the defaults (8 ns clock) an access finishes 38 cycles, 304 ns, after it is accepted.

Top module: `lcd_nibble_bridge`

## Requirements
- R1: After reset, `lcd_en`=0, `lcd_rw`=1, `lcd_rs`=0, `lcd_dq_oe`=0, `irq`=0, `bus_ready`=1, and the done flag (bit 8 of offset 0x0C) reads 0.
- R2: A write to offset 0x00 is accepted in a cycle with `bus_req` and `bus_ready` high. It becomes a display access with `lcd_rs`=0 and `lcd_rw`=0 that drives `bus_wdata[7:4]` on `lcd_dq_o`.
- R3: A write to offset 0x04 becomes a display access with `lcd_rs`=1 and `lcd_rw`=0 that drives `bus_wdata[7:4]`. Two successive writes place the upper and then the lower nibble of a byte on the link.
- R4: A read of offset 0x00 (`lcd_rs`=0) or 0x04 (`lcd_rs`=1) becomes a display access with `lcd_rw`=1 and `lcd_dq_oe`=0, and returns 0 on `bus_rdata`. The nibble on `lcd_dq_i` in the last enable-high cycle is captured. `lcd_dq_oe` is high only while a write access is in progress.
- R5: Each access spends ceil(SETUP_NS/CLK_NS) cycles with enable low after acceptance. Enable is then high for ceil(PULSE_NS/CLK_NS) cycles, and low for ceil(HOLD_NS/CLK_NS) more cycles. `lcd_rs`, `lcd_rw` and the write nibble stay constant throughout.
- R6: While an access is in progress, `bus_ready` is 0 for offsets 0x00 and 0x04 and 1 for every other offset. Outside an access it is 1.
- R7: The done flag is set at the end of every display access. A write to 0x0C with bit 8 = 0 clears it, and a write with bit 8 = 1 leaves it unchanged. Acceptance of a new display access clears it.
- R8: Offset 0x08 returns the captured nibble in bits [7:4] while the done flag is 1 and 0 otherwise. All its other bits are 0. Display writes leave the captured nibble unchanged.
- R9: Bit 0 of offset 0x10 is a read/write mask. Offset 0x14 bit 0 and `irq` both equal the done flag AND the mask.
- R10: Offsets 0x18 and above read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the accepting cycle |
| bus_ready | output | 1 | Request accepted this cycle when high with `bus_req` |
| irq | output | 1 | Done flag AND mask |
| lcd_rs | output | 1 | Register select, 1 = data register |
| lcd_rw | output | 1 | 1 = display read, 0 = display write |
| lcd_en | output | 1 | Enable strobe |
| lcd_dq_o | output | 4 | Nibble driven toward the display |
| lcd_dq_oe | output | 1 | Output enable for `lcd_dq_o` |
| lcd_dq_i | input | 4 | Nibble returned by the display |

## Verification
The assertions assume that `bus_addr`, `bus_we` and `bus_wdata` are held steady for as long as `bus_req` is high and `bus_ready` is low. They also assume the display returns its nibble on `lcd_dq_i` while enable is high. The stimulus follows both rules. It drives every request after a falling clock edge and holds it until an accepting rising edge. It sets the returned nibble before each display read is issued and does not change it until that read has finished. Register accesses are placed both inside and outside display accesses, so the hold-off path and the pass-through path are both exercised.

// File: rtl/lcd_bridge_pkg.sv
package lcd_bridge_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_PULSE,
        SQ_HOLD
    } seq_state_t;

    typedef enum logic [2:0] {
        RG_CMD  = 3'd0,
        RG_DATA = 3'd1,
        RG_CAPT = 3'd2,
        RG_FLAG = 3'd3,
        RG_MASK = 3'd4,
        RG_STAT = 3'd5,
        RG_NONE = 3'd7
    } reg_sel_t;

    typedef struct packed {
        logic       sel_data;
        logic       is_read;
        logic [3:0] nib;
    } lcd_op_t;

    localparam int unsigned NIB_LSB  = 4;
    localparam int unsigned DONE_BIT = 8;
    localparam int unsigned NUM_REGS = 6;

    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic reg_sel_t decode_word(input int unsigned word);
        reg_sel_t r;
        if (word < NUM_REGS) r = reg_sel_t'(word[2:0]);
        else                 r = RG_NONE;
        return r;
    endfunction

endpackage

// File: rtl/lcd_nibble_seq.sv
module lcd_nibble_seq
    import lcd_bridge_pkg::*;
#(
    parameter int unsigned SETUP_CYC = 5,
    parameter int unsigned PULSE_CYC = 30,
    parameter int unsigned HOLD_CYC  = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  lcd_op_t    op,
    input  logic [3:0] dq_i,
    output logic       idle,
    output logic       finish,
    output logic [3:0] capt_nib,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_en,
    output logic [3:0] dq_o,
    output logic       dq_oe
);
    localparam int unsigned MAX_CYC = max3(SETUP_CYC, PULSE_CYC, HOLD_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SET_LD  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PUL_LD  = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] HLD_LD  = CNT_W'(HOLD_CYC - 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    lcd_op_t          op_q;
    logic [3:0]       capt_q;
    logic             cnt_zero;
    logic             busy;

    assign cnt_zero = (cnt_q == '0);
    assign busy     = (state_q != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            op_q    <= '0;
            capt_q  <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (go) begin
                        op_q    <= op;
                        cnt_q   <= SET_LD;
                        state_q <= SQ_SETUP;
                    end
                end
                SQ_SETUP: begin
                    if (cnt_zero) begin
                        cnt_q   <= PUL_LD;
                        state_q <= SQ_PULSE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                SQ_PULSE: begin
                    if (cnt_zero) begin
                        if (op_q.is_read) capt_q <= dq_i;
                        cnt_q   <= HLD_LD;
                        state_q <= SQ_HOLD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                SQ_HOLD: begin
                    if (cnt_zero) state_q <= SQ_IDLE;
                    else          cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign idle     = !busy;
    assign finish   = (state_q == SQ_HOLD) && cnt_zero;
    assign capt_nib = capt_q;
    assign lcd_rs   = busy && op_q.sel_data;
    assign lcd_rw   = !busy || op_q.is_read;
    assign lcd_en   = (state_q == SQ_PULSE);
    assign dq_oe    = busy && !op_q.is_read;
    assign dq_o     = dq_oe ? op_q.nib : 4'h0;

endmodule

// File: rtl/lcd_bus_regs.sv
module lcd_bus_regs
    import lcd_bridge_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              irq,
    input  logic              seq_idle,
    input  logic              seq_finish,
    input  logic [3:0]        capt_nib,
    output logic              lcd_go,
    output lcd_op_t           go_op
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    reg_sel_t sel;
    logic     is_lcd;
    logic     accept;
    logic     wr_acc;
    logic     done_q;
    logic     mask_q;
    logic     unused_bits;

    assign sel    = decode_word(int'(bus_addr[ADDR_W-1:2]));
    assign is_lcd = (sel == RG_CMD) || (sel == RG_DATA);

    assign bus_ready = seq_idle || !is_lcd;
    assign accept    = bus_req && bus_ready;
    assign wr_acc    = accept && bus_we;
    assign lcd_go    = accept && is_lcd;

    assign go_op.sel_data = (sel == RG_DATA);
    assign go_op.is_read  = !bus_we;
    assign go_op.nib      = bus_wdata[NIB_LSB +: 4];

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            if (lcd_go)
                done_q <= 1'b0;
            else if (seq_finish)
                done_q <= 1'b1;
            else if (wr_acc && (sel == RG_FLAG) && !bus_wdata[DONE_BIT])
                done_q <= 1'b0;

            if (wr_acc && (sel == RG_MASK))
                mask_q <= bus_wdata[0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            RG_CAPT: if (done_q) bus_rdata[NIB_LSB +: 4] = capt_nib;
            RG_FLAG: bus_rdata[DONE_BIT] = done_q;
            RG_MASK: bus_rdata[0] = mask_q;
            RG_STAT: bus_rdata[0] = done_q && mask_q;
            default: bus_rdata = '0;
        endcase
    end

    assign irq = done_q && mask_q;

    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:DONE_BIT+1],
                           bus_wdata[DONE_BIT-1:NIB_LSB+4], bus_wdata[NIB_LSB-1:1],
                           WORD_W[0]};

endmodule

// File: rtl/lcd_nibble_bridge.sv
module lcd_nibble_bridge
    import lcd_bridge_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CLK_NS   = 8,
    parameter int unsigned SETUP_NS = 40,
    parameter int unsigned PULSE_NS = 240,
    parameter int unsigned HOLD_NS  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              irq,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic              lcd_en,
    output logic [3:0]        lcd_dq_o,
    output logic              lcd_dq_oe,
    input  logic [3:0]        lcd_dq_i
);
    localparam int unsigned SETUP_CYC = ns_to_cycles(SETUP_NS, CLK_NS);
    localparam int unsigned PULSE_CYC = ns_to_cycles(PULSE_NS, CLK_NS);
    localparam int unsigned HOLD_CYC  = ns_to_cycles(HOLD_NS, CLK_NS);

    logic       seq_idle;
    logic       seq_finish;
    logic [3:0] capt_nib;
    logic       lcd_go;
    lcd_op_t    go_op;

    lcd_bus_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk        (clk),
        .rst        (rst),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_ready  (bus_ready),
        .irq        (irq),
        .seq_idle   (seq_idle),
        .seq_finish (seq_finish),
        .capt_nib   (capt_nib),
        .lcd_go     (lcd_go),
        .go_op      (go_op)
    );

    lcd_nibble_seq #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .go       (lcd_go),
        .op       (go_op),
        .dq_i     (lcd_dq_i),
        .idle     (seq_idle),
        .finish   (seq_finish),
        .capt_nib (capt_nib),
        .lcd_rs   (lcd_rs),
        .lcd_rw   (lcd_rw),
        .lcd_en   (lcd_en),
        .dq_o     (lcd_dq_o),
        .dq_oe    (lcd_dq_oe)
    );

endmodule

// File: rtl/lcd_bridge_checker.sv
module lcd_bridge_checker
    import lcd_bridge_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned CLK_NS   = 8,
    parameter int unsigned PULSE_NS = 240
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ready,
    input logic              irq,
    input logic              lcd_rs,
    input logic              lcd_rw,
    input logic              lcd_en,
    input logic [3:0]        lcd_dq_o,
    input logic              lcd_dq_oe
);
    localparam int unsigned PULSE_CYC = ns_to_cycles(PULSE_NS, CLK_NS);

    logic        lcd_addr;
    int unsigned en_len;

    assign lcd_addr = (bus_addr[ADDR_W-1:2] == '0) || (int'(bus_addr[ADDR_W-1:2]) == 1);

    always_ff @(posedge clk) begin
        if (rst)         en_len <= 0;
        else if (lcd_en) en_len <= en_len + 1;
        else             en_len <= 0;
    end

    AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        lcd_dq_oe |-> !lcd_rw); // R4

    AST_EN_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_en) |-> ($stable(lcd_rs) && $stable(lcd_rw))); // R5

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_en) |-> (en_len == PULSE_CYC)); // R5

    AST_LINES_STEADY: assert property (@(posedge clk) disable iff (rst)
        lcd_en |=> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_dq_o))); // R5

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        (lcd_en && bus_req && lcd_addr) |-> !bus_ready); // R6

    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ready && lcd_addr) |=> !irq); // R7

endmodule

bind lcd_nibble_bridge lcd_bridge_checker #(
    .ADDR_W   (ADDR_W),
    .CLK_NS   (CLK_NS),
    .PULSE_NS (PULSE_NS)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_addr  (bus_addr),
    .bus_ready (bus_ready),
    .irq       (irq),
    .lcd_rs    (lcd_rs),
    .lcd_rw    (lcd_rw),
    .lcd_en    (lcd_en),
    .lcd_dq_o  (lcd_dq_o),
    .lcd_dq_oe (lcd_dq_oe)
);

// File: tb/lcd_nibble_bridge_tb.sv
module lcd_nibble_bridge_tb_top;

    localparam int S   = (40 + 7) / 8;
    localparam int P   = (240 + 7) / 8;
    localparam int H   = (20 + 7) / 8;
    localparam int TOT = S + P + H;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        irq;
    logic        lcd_rs, lcd_rw, lcd_en, lcd_dq_oe;
    logic [3:0]  lcd_dq_o;
    logic [3:0]  lcd_dq_i = 4'h0;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    lcd_nibble_bridge dut_i (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .irq(irq), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
        .lcd_en(lcd_en), .lcd_dq_o(lcd_dq_o), .lcd_dq_oe(lcd_dq_oe),
        .lcd_dq_i(lcd_dq_i)
    );

    // behavioural reference
    int       k = 0;
    bit       m_rs, m_rw, m_done, m_mask;
    bit [3:0] m_nib, m_capt;

    function automatic bit lcd_a(input logic [7:0] a);
        return (a == 8'h00) || (a == 8'h04);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit busy, acc;
        if (rst) begin
            k = 0; m_done = 0; m_mask = 0; m_capt = 0; m_rs = 0; m_rw = 1; m_nib = 0;
        end else begin
            busy = (k != 0);
            acc  = bus_req && !(busy && lcd_a(bus_addr));
            if (k != 0) begin
                if (k == S + P && m_rw) m_capt = lcd_dq_i;
                if (k == TOT) begin k = 0; m_done = 1; end
                else k = k + 1;
            end
            if (acc && lcd_a(bus_addr)) begin
                k = 1; m_rs = (bus_addr == 8'h04); m_rw = !bus_we;
                m_nib = bus_wdata[7:4]; m_done = 0;
            end
            if (acc && bus_we && bus_addr == 8'h0C && !bus_wdata[8]) m_done = 0;
            if (acc && bus_we && bus_addr == 8'h10) m_mask = bus_wdata[0];
        end
    end

    always @(posedge clk) begin
        bit busy, en_e;
        #2;
        if (!rst) begin
            busy = (k != 0);
            en_e = (k > S) && (k <= S + P);
            chk(lcd_en == en_e, "R5 en", lcd_en, en_e);
            chk(lcd_rw == (busy ? m_rw : 1'b1), "R2 rw", lcd_rw, busy ? m_rw : 1'b1);
            chk(lcd_rs == (busy ? m_rs : 1'b0), "R3 rs", lcd_rs, busy ? m_rs : 1'b0);
            chk(lcd_dq_oe == (busy && !m_rw), "R4 oe", lcd_dq_oe, busy && !m_rw);
            if (busy && !m_rw) chk(lcd_dq_o == m_nib, "R2 nibble", lcd_dq_o, m_nib);
            chk(irq == (m_done && m_mask), "R9 irq", irq, m_done && m_mask);
            chk(bus_ready == !(busy && lcd_a(bus_addr)), "R6 ready", bus_ready,
                !(busy && lcd_a(bus_addr)));
        end
    end

    task automatic acc_bus(input bit we, input logic [7:0] a, input logic [31:0] d,
                           output logic [31:0] rd);
        @(negedge clk);
        bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        while (!bus_ready) begin
            @(negedge clk);
            #1;
        end
        rd = bus_rdata;
        @(negedge clk);
        bus_req = 0; bus_we = 0; bus_addr = 8'h18; bus_wdata = '0;
    endtask

    task automatic wait_done();
        repeat (TOT + 2) @(posedge clk);
    endtask

    logic [31:0] rd;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        #1;
        chk(lcd_en == 0 && lcd_rw == 1 && lcd_rs == 0 && lcd_dq_oe == 0, "R1 pins",
            {lcd_en, lcd_rw, lcd_rs, lcd_dq_oe}, 4'b0100);
        chk(irq == 0 && bus_ready == 1, "R1 irq/ready", {irq, bus_ready}, 2'b01);
        acc_bus(0, 8'h0C, 0, rd);
        chk(rd == 0, "R1 done flag", rd, 0);

        // R2 command write
        acc_bus(1, 8'h00, 32'h0000_0038, rd);
        wait_done();
        acc_bus(0, 8'h0C, 0, rd);
        chk(rd == 32'h100, "R7 done set", rd, 32'h100);

        // R3 two data nibbles; R6 back-to-back hold-off
        acc_bus(1, 8'h04, 32'hFFFF_FFA0, rd);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = 8'h04; bus_wdata = 32'h5F;
        #1;
        chk(bus_ready == 0, "R6 held off", bus_ready, 0);
        bus_addr = 8'h10; bus_wdata = 0;
        #1;
        chk(bus_ready == 1, "R6 register pass", bus_ready, 1);
        bus_req = 0;
        acc_bus(1, 8'h04, 32'h0000_005F, rd);
        wait_done();

        // R4/R8 data read
        lcd_dq_i = 4'hC;
        acc_bus(0, 8'h04, 0, rd);
        chk(rd == 0, "R4 read return", rd, 0);
        wait_done();
        acc_bus(0, 8'h08, 0, rd);
        chk(rd == 32'hC0, "R8 capture", rd, 32'hC0);

        // R4 busy read with rs=0
        lcd_dq_i = 4'h3;
        acc_bus(0, 8'h00, 0, rd);
        chk(rd == 0, "R4 busy read return", rd, 0);
        wait_done();
        acc_bus(0, 8'h08, 0, rd);
        chk(rd == 32'h30, "R8 capture second", rd, 32'h30);

        // R8 write leaves capture
        acc_bus(1, 8'h04, 32'h90, rd);
        wait_done();
        acc_bus(0, 8'h08, 0, rd);
        chk(rd == 32'h30, "R8 write keeps capture", rd, 32'h30);

        // R7 write-1 no effect, write-0 clears
        acc_bus(1, 8'h0C, 32'hFFFF_FFFF, rd);
        acc_bus(0, 8'h0C, 0, rd);
        chk(rd == 32'h100, "R7 write one ignored", rd, 32'h100);
        acc_bus(1, 8'h0C, 32'hFFFF_FEFF, rd);
        acc_bus(0, 8'h0C, 0, rd);
        chk(rd == 0, "R7 write zero clears", rd, 0);
        acc_bus(0, 8'h08, 0, rd);
        chk(rd == 0, "R8 hidden when not done", rd, 0);

        // R9 mask and status
        acc_bus(1, 8'h10, 32'h1, rd);
        acc_bus(0, 8'h14, 0, rd);
        chk(rd == 0, "R9 status off", rd, 0);
        acc_bus(1, 8'h00, 32'h10, rd);
        wait_done();
        chk(irq == 1, "R9 irq on", irq, 1);
        acc_bus(0, 8'h14, 0, rd);
        chk(rd == 1, "R9 status on", rd, 1);
        acc_bus(0, 8'h10, 0, rd);
        chk(rd == 1, "R9 mask readback", rd, 1);
        acc_bus(1, 8'h04, 32'h20, rd);
        chk(irq == 0, "R7 new access clears", irq, 0);
        wait_done();

        // R10 unmapped
        acc_bus(1, 8'h18, 32'hFFFF_FFFF, rd);
        acc_bus(1, 8'h1C, 32'h0, rd);
        acc_bus(0, 8'h18, 0, rd);
        chk(rd == 0, "R10 unmapped read", rd, 0);
        acc_bus(0, 8'h10, 0, rd);
        chk(rd == 1, "R10 mask untouched", rd, 1);
        acc_bus(0, 8'h0C, 0, rd);
        chk(rd == 32'h100, "R10 flag untouched", rd, 32'h100);

        repeat (4) @(posedge clk);
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!ended) begin
            ended = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule